// File: doc/BRIEF.md
# Multi-Channel Cell Receive Port

This block is the physical-layer end of the receive direction on a shared byte-wide cell bus that serves three channels. Each channel has its own byte buffer. A line-side fill port writes bytes into these buffers in arrival order. A cell is always 53 bytes: five header bytes, then 48 payload bytes. A channel only tells the cell-layer device that it can send once every byte of a cell is stored.

The cell-layer device controls each channel through a separate enable line. It can raise or drop that line in any cycle, including in the middle of a cell. On every rising clock edge where an enabled channel is allowed to send, the block moves that channel's next byte onto the shared data bus. Alongside the byte it drives an odd-parity bit, and a start-of-cell flag on the first header byte. Two modes are available, and they differ only in how the available flag behaves while a cell is in progress:

- **Whole-cell mode:** the flag counts only cells that have not started yet. The cell-layer device ignores the flag once a cell is under way.
- **Per-byte mode:** the flag paces each byte, so it stays high while the current cell still has bytes to send.

Top module: `ucell_rx_port`

## Requirements
- R1: With `byte_mode`=0, `rx_clav[c]` is high exactly when channel c holds at least one complete unstarted 53-byte cell. It rises in the cycle after the rising edge that writes the 53rd byte of a cell.
- R2: At a rising edge where channel c is enabled (`rx_en[c]`=1) and is either in mid-cell or has a complete cell, c's oldest unsent byte appears on `rx_data` after that edge. Bytes leave in the order they were written, so the five header bytes come out before the 48 payload bytes.
- R3: `rx_soc` is 1 during exactly the cycle in which the first byte of a cell is on `rx_data`, and 0 in every other cycle.
- R4: `rx_par` is always chosen so that `rx_data` together with `rx_par` holds an odd number of ones.
- R5: In a cycle that follows an edge with no transfer, `rx_data` is 0, `rx_par` is 1 and `rx_soc` is 0.
- R6: Dropping `rx_en[c]` in the middle of a cell pauses that cell. When the enable returns, the transfer continues with the next byte, and nothing is lost or repeated.
- R7: With `byte_mode`=0, a started cell keeps transferring even when `rx_clav[c]` is low. During the cell, `rx_clav[c]` shows only whether a further complete cell is waiting.
- R8: With `byte_mode`=1, `rx_clav[c]` stays high from the edge that takes a cell's first byte until the edge that takes its 53rd byte. When the channel is not in mid-cell, the flag follows the R1 rule.
- R9: If several enabled channels can send at the same edge, the lowest-numbered one is served. The others keep their position.
- R10: A fill write to a channel whose buffer already holds SLOTS×53 unsent bytes is dropped. The same applies to a write whose `lw_ch` is not a valid channel number.
- R11: After reset, every `rx_clav` bit is 0, `rx_data` is 0, `rx_par` is 1 and `rx_soc` is 0.
- R12: An enable on a channel that is not in mid-cell and holds no complete cell causes no transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running receive clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| byte_mode | input | 1 | 0 selects whole-cell mode, 1 selects per-byte mode |
| lw_en | input | 1 | Fill-port write strobe |
| lw_ch | input | 2 | Channel that the fill write targets |
| lw_data | input | 8 | Fill-port byte |
| rx_en | input | 3 | Per-channel enable from the cell-layer device |
| rx_clav | output | 3 | Per-channel cell-available flag |
| rx_data | output | 8 | Shared data bus |
| rx_par | output | 1 | Odd parity over `rx_data` |
| rx_soc | output | 1 | Start-of-cell flag |

## Verification
A wrong read pointer or a wrong in-cell position shows up on the bus at the next transfer from that channel. It appears as a wrong byte, or as `rx_soc` landing on a byte other than the first of a cell. A wrong complete-cell count appears on `rx_clav` in the cycle after the write or the start of cell that updated it. The error then stays visible until the channel is drained. The bench runs a reference queue for each channel alongside the design and compares every output in every cycle. As a result, a fault can be seen at most one byte transfer after it occurs.

// File: rtl/ucell_pkg.sv
package ucell_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic logic odd_par(input logic [BYTE_W-1:0] d);
    return ~(^d);
  endfunction
endpackage

// File: rtl/ucell_chan_buf.sv
module ucell_chan_buf #(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned SLOTS    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       pop,
  output logic       has_cell,
  output logic       mid_cell,
  output logic [7:0] head_byte
);
  localparam int unsigned DEPTH = CELL_LEN * SLOTS;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned PW    = $clog2(CELL_LEN);
  localparam int unsigned NW    = $clog2(SLOTS + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] wpos_q, wpos_d, rpos_q, rpos_d;
  logic [NW-1:0] ncell_q, ncell_d;
  logic          mid_q, mid_d;
  logic          accept, wr_last, rd_first, rd_last;

  always_comb begin
    accept   = wr_en && (cnt_q != CW'(DEPTH));
    wr_last  = accept && (wpos_q == PW'(CELL_LEN - 1));
    rd_first = pop && !mid_q;
    rd_last  = pop && (rpos_q == PW'(CELL_LEN - 1));

    wptr_d  = wptr_q;
    wpos_d  = wpos_q;
    if (accept) begin
      wptr_d = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      wpos_d = wr_last ? '0 : wpos_q + 1'b1;
    end

    rptr_d = rptr_q;
    rpos_d = rpos_q;
    if (pop) begin
      rptr_d = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      rpos_d = rd_last ? '0 : rpos_q + 1'b1;
    end

    cnt_d   = cnt_q + CW'(accept) - CW'(pop);
    ncell_d = ncell_q + NW'(wr_last) - NW'(rd_first);

    if (rd_last)       mid_d = 1'b0;
    else if (rd_first) mid_d = 1'b1;
    else               mid_d = mid_q;
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      wpos_q  <= '0;
      rpos_q  <= '0;
      ncell_q <= '0;
      mid_q   <= 1'b0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      cnt_q   <= cnt_d;
      wpos_q  <= wpos_d;
      rpos_q  <= rpos_d;
      ncell_q <= ncell_d;
      mid_q   <= mid_d;
    end
  end

  assign has_cell  = (ncell_q != '0);
  assign mid_cell  = mid_q;
  assign head_byte = mem[rptr_q];

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt_q == CW'(DEPTH) && !pop) |=> (cnt_q == CW'(DEPTH)));
  p_start_needs_cell_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !mid_q) |-> (ncell_q != '0));
  p_pop_has_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/ucell_prio_pick.sv
module ucell_prio_pick #(
  parameter int unsigned N  = 3,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    gnt = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req[i] && !any) begin
        gnt[i] = 1'b1;
        any    = 1'b1;
        idx    = IW'(i);
      end
    end
  end

  always_comb begin
    p_grant_subset_r9: assert ((gnt & ~req) == '0);
  end
endmodule

// File: rtl/ucell_rx_port.sv
module ucell_rx_port #(
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned SLOTS    = 2,
  localparam int unsigned CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              lw_en,
  input  logic [CHW-1:0]    lw_ch,
  input  logic [7:0]        lw_data,
  input  logic [NUM_CH-1:0] rx_en,
  output logic [NUM_CH-1:0] rx_clav,
  output logic [7:0]        rx_data,
  output logic              rx_par,
  output logic              rx_soc
);
  import ucell_pkg::*;

  logic [1:0] rs_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  logic [NUM_CH-1:0] has, mid, req, gnt;
  logic [7:0]        head [NUM_CH];
  logic              any;
  logic [CHW-1:0]    sel;

  for (genvar g = 0; g < int'(NUM_CH); g++) begin : g_ch
    ucell_chan_buf #(.CELL_LEN(CELL_LEN), .SLOTS(SLOTS)) u_buf (
      .clk      (clk),
      .rst_n    (rst_q),
      .wr_en    (lw_en && (lw_ch == CHW'(g))),
      .wr_data  (lw_data),
      .pop      (gnt[g]),
      .has_cell (has[g]),
      .mid_cell (mid[g]),
      .head_byte(head[g])
    );
    assign req[g]     = rx_en[g] && (mid[g] || has[g]);
    assign rx_clav[g] = byte_mode ? (mid[g] || has[g]) : has[g];
  end

  ucell_prio_pick #(.N(NUM_CH)) u_pick (
    .req(req),
    .gnt(gnt),
    .any(any),
    .idx(sel)
  );

  logic [7:0] data_d, data_q;
  logic       soc_d, soc_q, par_d, par_q;

  always_comb begin
    data_d = any ? head[sel] : 8'h00;
    soc_d  = any && !mid[sel];
    par_d  = odd_par(data_d);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      data_q <= 8'h00;
      soc_q  <= 1'b0;
      par_q  <= 1'b1;
    end else begin
      data_q <= data_d;
      soc_q  <= soc_d;
      par_q  <= par_d;
    end
  end

  assign rx_data = data_q;
  assign rx_par  = par_q;
  assign rx_soc  = soc_q;

  p_odd_par_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (^{rx_data, rx_par}) == 1'b1);
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !any |=> (rx_data == 8'h00 && rx_par && !rx_soc));
  p_soc_first_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (any && mid[sel]) |=> !rx_soc);
endmodule

// File: tb/sim_ucell_rx_port.sv
module sim_ucell_rx_port;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;
  localparam int CL  = 53;
  localparam int SL  = 2;
  localparam int CAP = CL * SL;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           byte_mode = 1'b0;
  logic           lw_en = 1'b0;
  logic [1:0]     lw_ch = '0;
  logic [7:0]     lw_data = '0;
  logic [NCH-1:0] rx_en = '0;
  logic [NCH-1:0] rx_clav;
  logic [7:0]     rx_data;
  logic           rx_par, rx_soc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ucell_rx_port u0 (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
    .lw_en(lw_en), .lw_ch(lw_ch), .lw_data(lw_data),
    .rx_en(rx_en), .rx_clav(rx_clav), .rx_data(rx_data),
    .rx_par(rx_par), .rx_soc(rx_soc)
  );

  int checks = 0;
  int fails  = 0;

  logic [7:0] mq [NCH][$];
  int         mwpos [NCH];
  int         mncell [NCH];
  int         mrpos [NCH];
  bit         mmid [NCH];

  logic [7:0]     exp_data;
  logic           exp_par, exp_soc;
  logic [NCH-1:0] exp_clav;
  string          ptag;

  function automatic logic par_of(input logic [7:0] d);
    return ~(^d);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h @%0t", tag, ptag, act, expv, $time);
    end
  endtask

  // Drive one cycle's inputs and advance the reference model to post-edge values.
  task automatic apply(input bit bm, input bit wen, input int wch,
                       input logic [7:0] wd, input logic [NCH-1:0] en);
    int g;
    int szb;
    byte_mode = bm; lw_en = wen; lw_ch = 2'(wch); lw_data = wd; rx_en = en;
    szb = (wch < NCH) ? mq[wch].size() : CAP;
    g = -1;
    for (int c = 0; c < NCH; c++)
      if (g < 0 && en[c] && (mmid[c] || mncell[c] > 0)) g = c;
    if (g >= 0) begin
      exp_data = mq[g].pop_front();
      exp_soc  = !mmid[g];
      if (!mmid[g]) begin mncell[g]--; mmid[g] = 1; end
      mrpos[g]++;
      if (mrpos[g] == CL) begin mmid[g] = 0; mrpos[g] = 0; end
    end else begin
      exp_data = 8'h00;
      exp_soc  = 1'b0;
    end
    if (wen && wch < NCH && szb < CAP) begin
      mq[wch].push_back(wd);
      mwpos[wch]++;
      if (mwpos[wch] == CL) begin mncell[wch]++; mwpos[wch] = 0; end
    end
    exp_par = par_of(exp_data);
    for (int c = 0; c < NCH; c++)
      exp_clav[c] = bm ? (mmid[c] || mncell[c] > 0) : (mncell[c] > 0);
  endtask

  task automatic compare(input bit bm);
    chk(rx_data == exp_data, "R2 R6 R9 R10 R12 data", rx_data, exp_data);
    chk(rx_par == exp_par, "R4 parity", rx_par, exp_par);
    chk(rx_soc == exp_soc, "R3 soc", rx_soc, exp_soc);
    if (exp_data == 8'h00 && !exp_soc)
      chk(rx_data == 8'h00 && rx_par, "R5 idle bus", {rx_par, rx_data}, 9'h100);
    if (bm) chk(rx_clav == exp_clav, "R8 clav byte mode", rx_clav, exp_clav);
    else    chk(rx_clav == exp_clav, "R1 R7 clav cell mode", rx_clav, exp_clav);
  endtask

  task automatic step(input bit bm, input bit wen, input int wch,
                      input logic [7:0] wd, input logic [NCH-1:0] en);
    apply(bm, wen, wch, wd, en);
    @(posedge clk);
    @(negedge clk);
    compare(bm);
  endtask

  task automatic fill_cell(input bit bm, input int ch, input logic [7:0] base);
    for (int i = 0; i < CL; i++) step(bm, 1'b1, ch, base + 8'(i), '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3d5));
    for (int c = 0; c < NCH; c++) begin
      mwpos[c] = 0; mncell[c] = 0; mrpos[c] = 0; mmid[c] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    ptag = "R11 reset";
    chk(rx_clav == '0, "R11 clav", rx_clav, 0);
    chk(rx_data == 8'h00, "R11 data", rx_data, 0);
    chk(rx_par == 1'b1, "R11 par", rx_par, 1);
    chk(rx_soc == 1'b0, "R11 soc", rx_soc, 0);

    ptag = "R12 enable empty";
    repeat (3) step(0, 0, 0, 0, 3'b111);

    ptag = "R1 fill and R7 single cell";
    fill_cell(0, 0, 8'h10);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 3'b001);
    ptag = "R6 pause";
    for (int i = 0; i < 60; i++) step(0, 0, 0, 0, (i % 3 == 0) ? 3'b000 : 3'b001);

    ptag = "R9 priority";
    fill_cell(0, 1, 8'h40);
    fill_cell(0, 2, 8'h80);
    for (int i = 0; i < 120; i++) step(0, 0, 0, 0, 3'b110);

    ptag = "R10 overflow";
    for (int i = 0; i < CAP + 15; i++) step(0, 1, 2, 8'(i * 7 + 3), '0);
    step(0, 1, 3, 8'h55, '0);
    for (int i = 0; i < CAP + 5; i++) step(0, 0, 0, 0, 3'b100);

    ptag = "R8 byte mode";
    fill_cell(1, 1, 8'hA0);
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, 3'b010);
    for (int i = 0; i < 30; i++) step(1, 0, 0, 0, (i % 2) ? 3'b010 : 3'b000);

    ptag = "random";
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 2500; i++) begin
        int r;
        logic [NCH-1:0] en;
        r  = int'($urandom % 100);
        en = (r < 55) ? NCH'(1 << ($urandom % NCH)) : (r < 75) ? NCH'($urandom) : '0;
        step(ph[0], ($urandom % 100) < 60, int'($urandom % 4),
             8'($urandom), en);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule